// File: doc/BRIEF.md
# DRAM ECC Error Log

This block records DRAM ECC error events for a two-channel memory controller and reports them. The controller pulses a correctable-error or uncorrectable-error input for one cycle. Each pulse comes with a 33-bit physical address, the channel number and the 8-bit ECC syndrome. Three more single-cycle event inputs report a refresh timeout, a locked access to non-DRAM memory and a thermal sensor trip.

Every event sets a sticky flag in a 16-bit status register. Software clears a flag by writing 1 to it. The details of one ECC error are held in three capture registers: an address pointer with a 128-byte grain that also carries the channel, an extended register that holds address bit 32, and a syndrome register. An uncorrectable error replaces a logged correctable error. A 16-bit enable register chooses which flags drive the single SERR level output.

Software reaches all registers through a simple port. The port takes a write strobe, a 3-bit register select and 32-bit write data, and returns combinational read data.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every register reads zero and `serr` is low.
- R2: A pulse sets its status flag at the next clock edge: correctable in bit 0, uncorrectable in bit 1, refresh timeout in bit 8, non-DRAM lock in bit 9, thermal in bit 11. All other status bits read zero. The status register is at select 0.
- R3: Writing select 0 clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 stay unchanged.
- R4: If a flag's event and a clear of that same flag arrive in the same cycle, the flag stays set.
- R5: A correctable error is captured only when no error flag (mask 0x0B03) is set. The capture stores the address, the channel and the syndrome.
- R6: An uncorrectable error is captured in two cases: when no error flag is set, or when bit 0 is set and bit 1 is clear. In the second case it overwrites the correctable error's details. If both kinds of error pulse in the same cycle, the uncorrectable one is captured.
- R7: While status bit 1 is set, the capture registers do not change. A correctable error never overwrites the capture registers while any error flag is set.
- R8: Select 2 reads `{addr[31:7], 6'b0, channel}`. Select 3 reads address bit 32 in bit 0 and zero above it. Select 4 reads the syndrome in bits 7:0 and zero above it.
- R9: Select 1 is the enable register. Bits 0, 1, 8, 9 and 11 are writable. All other bits read zero.
- R10: `serr` is high exactly when some status flag and its matching enable bit are both set. It follows the registers with no extra delay.
- R11: Writes to selects 2 to 7 have no effect. Selects 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceValid | input | 1 | Correctable error pulse |
| ueValid | input | 1 | Uncorrectable error pulse |
| errAddr | input | 33 | Physical address of the error |
| errChan | input | 1 | Channel of the error |
| errSyn | input | 8 | ECC syndrome of the error |
| refreshTimeout | input | 1 | Refresh timeout event pulse |
| lockNonDram | input | 1 | Lock to non-DRAM memory event pulse |
| thermalEvent | input | 1 | Thermal sensor event pulse |
| regWe | input | 1 | Register write strobe |
| regSel | input | 3 | Register select |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational |
| serr | output | 1 | System error level |

## Verification
Directed sequences first apply a correctable error and then an uncorrectable one. This separates the overwrite case from the opposite order, where the uncorrectable details must be kept. A clear that lands in the same cycle as a new event separates event priority from clear priority. Writes of all-ones to the enable register, to the read-only selects and to the reserved status bits show which bits are live. A randomized stream then mixes bursts of errors, side-band events, partial clears and enable changes. In this stream the capture gating is tried with flags left partly set, so a correctable error that arrives after only a side-band flag is cleared is told apart from one that arrives into an empty log.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int STAT_W = 16;
  localparam logic [STAT_W-1:0] ERR_MASK = 16'h0B03;
  localparam int BIT_CE  = 0;
  localparam int BIT_UE  = 1;
  localparam int BIT_RTO = 8;
  localparam int BIT_LCK = 9;
  localparam int BIT_THM = 11;

  localparam logic [2:0] SEL_STAT = 3'd0;
  localparam logic [2:0] SEL_EN   = 3'd1;
  localparam logic [2:0] SEL_PTR  = 3'd2;
  localparam logic [2:0] SEL_EXT  = 3'd3;
  localparam logic [2:0] SEL_SYN  = 3'd4;

  typedef struct packed {
    logic [STAT_W-1:0] setBits;
    logic [STAT_W-1:0] clrBits;
    logic              enWe;
    logic              loadLog;
  } strobe_t;
endpackage

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic              ceValid,
  input  logic              ueValid,
  input  logic              refreshTimeout,
  input  logic              lockNonDram,
  input  logic              thermalEvent,
  input  logic              regWe,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [STAT_W-1:0] regWdata,
  input  logic [STAT_W-1:0] statusQ,
  output strobe_t           strb
);
  logic logFree;
  logic ceLogged;
  logic loadUe;
  logic loadCe;

  // The capture registers are free only when no error flag is set.
  assign logFree  = (statusQ & ERR_MASK) == '0;
  assign ceLogged = statusQ[BIT_CE] & ~statusQ[BIT_UE];
  assign loadUe   = ueValid & (logFree | ceLogged);
  assign loadCe   = ceValid & ~ueValid & logFree;

  always_comb begin
    strb = '0;
    strb.setBits[BIT_CE]  = ceValid;
    strb.setBits[BIT_UE]  = ueValid;
    strb.setBits[BIT_RTO] = refreshTimeout;
    strb.setBits[BIT_LCK] = lockNonDram;
    strb.setBits[BIT_THM] = thermalEvent;
    if (regWe && regSel == SEL_W'(SEL_STAT))
      strb.clrBits = regWdata & ERR_MASK;
    strb.enWe    = regWe && regSel == SEL_W'(SEL_EN);
    strb.loadLog = loadUe | loadCe;
  end
endmodule

// File: rtl/ecc_log_dpath.sv
module ecc_log_dpath
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W     = 33,
  parameter int SYN_W      = 8,
  parameter int GRAIN_LOG2 = 7,
  parameter int DATA_W     = 32,
  parameter int SEL_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic              errChan,
  input  logic [SYN_W-1:0]  errSyn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [STAT_W-1:0] regWdata,
  output logic [STAT_W-1:0] statusQ,
  output logic [DATA_W-1:0] regRdata,
  output logic              serr
);
  localparam int EXT_W = ADDR_W - DATA_W;

  logic [STAT_W-1:0]          enableQ;
  logic [ADDR_W-1:GRAIN_LOG2] logAddr;
  logic                       logChan;
  logic [SYN_W-1:0]           logSyn;
  logic                       unusedAddrLow;

  assign unusedAddrLow = ^errAddr[GRAIN_LOG2-1:0];

  // Only the defined flag positions get a flop; the rest are tied low.
  for (genvar b = 0; b < STAT_W; b++) begin : gBit
    if (ERR_MASK[b]) begin : gLive
      logic stFf;
      logic enFf;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stFf <= 1'b0;
          enFf <= 1'b0;
        end else begin
          stFf <= strb.setBits[b] | (stFf & ~strb.clrBits[b]);
          if (strb.enWe) enFf <= regWdata[b];
        end
      end
      assign statusQ[b] = stFf;
      assign enableQ[b] = enFf;
    end else begin : gRsvd
      assign statusQ[b] = 1'b0;
      assign enableQ[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      logAddr <= '0;
      logChan <= 1'b0;
      logSyn  <= '0;
    end else if (strb.loadLog) begin
      logAddr <= errAddr[ADDR_W-1:GRAIN_LOG2];
      logChan <= errChan;
      logSyn  <= errSyn;
    end
  end

  assign serr = |(statusQ & enableQ);

  always_comb begin
    regRdata = '0;
    case (regSel)
      SEL_W'(SEL_STAT): regRdata[STAT_W-1:0] = statusQ;
      SEL_W'(SEL_EN):   regRdata[STAT_W-1:0] = enableQ;
      SEL_W'(SEL_PTR): begin
        regRdata[DATA_W-1:GRAIN_LOG2] = logAddr[DATA_W-1:GRAIN_LOG2];
        regRdata[0] = logChan;
      end
      SEL_W'(SEL_EXT):  regRdata[EXT_W-1:0] = logAddr[ADDR_W-1:DATA_W];
      SEL_W'(SEL_SYN):  regRdata[SYN_W-1:0] = logSyn;
      default:          regRdata = '0;
    endcase
  end

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.setBits) |=> ((statusQ & $past(strb.setBits)) == $past(strb.setBits))); // R4

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (|(strb.clrBits & ~strb.setBits)) |=>
      ((statusQ & $past(strb.clrBits & ~strb.setBits)) == '0)); // R3

  AST_UE_LOG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[BIT_UE] |=> ($stable(logAddr) && $stable(logChan) && $stable(logSyn))); // R7

  AST_SERR_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    ((|(strb.setBits & enableQ)) && !strb.enWe) |=> serr); // R10
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W     = 33,
  parameter int SYN_W      = 8,
  parameter int GRAIN_LOG2 = 7,
  parameter int DATA_W     = 32,
  parameter int SEL_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceValid,
  input  logic              ueValid,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic              errChan,
  input  logic [SYN_W-1:0]  errSyn,
  input  logic              refreshTimeout,
  input  logic              lockNonDram,
  input  logic              thermalEvent,
  input  logic              regWe,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              serr
);
  strobe_t           strb;
  logic [STAT_W-1:0] statusQ;
  logic              unusedWdHi;

  assign unusedWdHi = ^regWdata[DATA_W-1:STAT_W];

  ecc_log_ctrl #(.SEL_W(SEL_W)) uCtrl (
    .ceValid        (ceValid),
    .ueValid        (ueValid),
    .refreshTimeout (refreshTimeout),
    .lockNonDram    (lockNonDram),
    .thermalEvent   (thermalEvent),
    .regWe          (regWe),
    .regSel         (regSel),
    .regWdata       (regWdata[STAT_W-1:0]),
    .statusQ        (statusQ),
    .strb           (strb)
  );

  ecc_log_dpath #(
    .ADDR_W(ADDR_W), .SYN_W(SYN_W), .GRAIN_LOG2(GRAIN_LOG2),
    .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .errAddr  (errAddr),
    .errChan  (errChan),
    .errSyn   (errSyn),
    .regSel   (regSel),
    .regWdata (regWdata[STAT_W-1:0]),
    .statusQ  (statusQ),
    .regRdata (regRdata),
    .serr     (serr)
  );
endmodule

// File: tb/ecc_err_log_test.sv
`timescale 1ns/1ps
module ecc_err_log_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceValid = 0, ueValid = 0, errChan = 0;
  logic [32:0] errAddr = '0;
  logic [7:0]  errSyn = '0;
  logic        refreshTimeout = 0, lockNonDram = 0, thermalEvent = 0;
  logic        regWe = 0;
  logic [2:0]  regSel = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        serr;

  int testCnt = 0;
  int failCnt = 0;

  // Expected state, derived from the requirements.
  logic [15:0] mSt = '0, mEn = '0;
  logic [32:7] mAddr = '0;
  logic        mChan = 0;
  logic [7:0]  mSyn = '0;

  localparam logic [15:0] MASK = 16'h0B03;

  always #2 clk = ~clk;

  ecc_err_log uut (
    .clk(clk), .rstN(rstN), .ceValid(ceValid), .ueValid(ueValid),
    .errAddr(errAddr), .errChan(errChan), .errSyn(errSyn),
    .refreshTimeout(refreshTimeout), .lockNonDram(lockNonDram),
    .thermalEvent(thermalEvent), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .serr(serr)
  );

  function automatic logic [31:0] expRead(input logic [2:0] s);
    case (s)
      3'd0: return {16'h0, mSt};
      3'd1: return {16'h0, mEn};
      3'd2: return {mAddr[31:7], 6'b0, mChan};
      3'd3: return {31'b0, mAddr[32]};
      3'd4: return {24'b0, mSyn};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readSel(input logic [2:0] s, output logic [31:0] v);
    regWe = 0;
    regSel = s;
    #0.1;
    v = regRdata;
  endtask

  task automatic checkAll();
    logic [31:0] v;
    string tags [8] = '{"R2", "R9", "R8", "R8", "R8", "R11", "R11", "R11"};
    for (int s = 0; s < 8; s++) begin
      readSel(3'(s), v);
      check(tags[s], v, expRead(3'(s)));
    end
    check("R10", {31'b0, serr}, {31'b0, |(mSt & mEn)});
  endtask

  // Drive one cycle of stimulus just after a falling edge and update the model.
  task automatic step(input logic ce, ue, rto, lck, thm, we,
                      input logic [2:0] sel, input logic [31:0] wd,
                      input logic [32:0] a, input logic ch, input logic [7:0] sy);
    logic [15:0] setV, clrV;
    logic freeV, ldUe, ldCe;
    ceValid = ce; ueValid = ue; refreshTimeout = rto; lockNonDram = lck;
    thermalEvent = thm; regWe = we; regSel = sel; regWdata = wd;
    errAddr = a; errChan = ch; errSyn = sy;
    setV = '0;
    setV[0] = ce; setV[1] = ue; setV[8] = rto; setV[9] = lck; setV[11] = thm;
    clrV = (we && sel == 3'd0) ? (wd[15:0] & MASK) : 16'h0;
    freeV = (mSt & MASK) == 16'h0;
    ldUe = ue && (freeV || (mSt[0] && !mSt[1]));
    ldCe = ce && !ue && freeV;
    if (ldUe || ldCe) begin
      mAddr = a[32:7]; mChan = ch; mSyn = sy;
    end
    if (we && sel == 3'd1) mEn = wd[15:0] & MASK;
    mSt = (mSt & ~clrV) | setV;
    @(posedge clk);
    @(negedge clk);
    ceValid = 0; ueValid = 0; refreshTimeout = 0; lockNonDram = 0;
    thermalEvent = 0; regWe = 0;
  endtask

  task automatic idleW(input logic [2:0] sel, input logic [31:0] wd);
    step(0, 0, 0, 0, 0, 1, sel, wd, 33'h0, 0, 8'h0);
  endtask

  initial begin
    #800000;
    failCnt++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    for (int s = 0; s < 8; s++) begin
      readSel(3'(s), v);
      check("R1", v, 32'h0);
    end
    check("R1", {31'b0, serr}, 32'h0);

    // R5: correctable error into an empty log
    step(1, 0, 0, 0, 0, 0, 0, 0, 33'h1_2345_6789, 1, 8'h5A);
    readSel(3'd2, v); check("R5", v, 32'h2345_6781);
    readSel(3'd3, v); check("R5", v, 32'h1);
    readSel(3'd4, v); check("R5", v, 32'h5A);
    readSel(3'd0, v); check("R2", v, 32'h1);

    // R6: uncorrectable error overwrites the correctable details
    step(0, 1, 0, 0, 0, 0, 0, 0, 33'h0_ABCD_EF80, 0, 8'hC3);
    readSel(3'd2, v); check("R6", v, 32'hABCD_EF80);
    readSel(3'd4, v); check("R6", v, 32'hC3);
    readSel(3'd0, v); check("R2", v, 32'h3);

    // R7: a later correctable error leaves the uncorrectable details alone
    step(1, 0, 0, 0, 0, 0, 0, 0, 33'h1_1111_1111, 1, 8'h11);
    readSel(3'd2, v); check("R7", v, 32'hABCD_EF80);

    // R3: a zero write bit keeps the flag; a one write bit clears it
    idleW(3'd0, 32'h0000_0001);
    readSel(3'd0, v); check("R3", v, 32'h2);
    idleW(3'd0, 32'hFFFF_FFFF);
    readSel(3'd0, v); check("R3", v, 32'h0);

    // R4: an event and a clear of the same flag in the same cycle
    step(0, 0, 1, 0, 0, 1, 3'd0, 32'h0000_0100, 33'h0, 0, 8'h0);
    readSel(3'd0, v); check("R4", v, 32'h100);

    // R9: only the live enable bits take a write
    idleW(3'd1, 32'hFFFF_FFFF);
    readSel(3'd1, v); check("R9", v, 32'h0B03);
    check("R10", {31'b0, serr}, 32'h1);
    idleW(3'd1, 32'h0000_0800);
    check("R10", {31'b0, serr}, 32'h0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 33'h0, 0, 8'h0);
    check("R10", {31'b0, serr}, 32'h1);

    // R11: writes to read-only selects are ignored
    idleW(3'd2, 32'hFFFF_FFFF);
    idleW(3'd4, 32'hFFFF_FFFF);
    idleW(3'd6, 32'hFFFF_FFFF);
    readSel(3'd2, v); check("R11", v, 32'hABCD_EF80);
    readSel(3'd4, v); check("R11", v, 32'hC3);

    // R6: both error kinds together into a cleared log; the uncorrectable one wins
    idleW(3'd0, 32'h0000_0B03);
    step(1, 1, 0, 0, 0, 0, 0, 0, 33'h0_0000_0F00, 1, 8'h77);
    readSel(3'd2, v); check("R6", v, 32'h0000_0F01);
    readSel(3'd4, v); check("R6", v, 32'h77);
    checkAll();

    // Randomised mix checked against the model
    for (int i = 0; i < 3000; i++) begin
      logic we;
      logic [2:0] sel;
      logic [31:0] wd;
      we  = ($urandom % 3) == 0;
      sel = ($urandom % 2 == 0) ? 3'd0 : 3'($urandom % 8);
      wd  = ($urandom % 2 == 0) ? 32'h0B03 : $urandom;
      step(($urandom % 4) == 0, ($urandom % 10) == 0, ($urandom % 16) == 0,
           ($urandom % 16) == 0, ($urandom % 16) == 0, we, sel, wd,
           {1'($urandom), 32'($urandom)}, 1'($urandom), 8'($urandom));
      checkAll();
    end

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule